// File: doc/BRIEF.md
# Single-Precision Rounding and Overflow Unit

This unit is the last stage of a single-precision arithmetic pipe. It receives a result that is already normalized but not yet rounded: a sign, a biased exponent held in a widened signed field, a 24-bit significand with its leading one, and three extra bits below the significand (guard, round and sticky). It applies one of four directed rounding modes and absorbs a carry that runs out of the significand. It then tests the rounded exponent for overflow and packs the final 32-bit word.

On overflow the unit does one of two things. If the overflow trap is not enabled, it substitutes a default value: either the largest finite magnitude or infinity, picked by the mode and the sign. If the trap is enabled, it raises a trap request and delivers the correctly rounded value with its biased exponent lowered by 192, so that a handler can still see the value.

An optional output register loads on an input valid strobe. It presents the word and the flags one clock later, together with an output valid.

Top module: `fpr_round_unit`

## Requirements
- R1: Mode code 00 is round-to-nearest, so a mode input tied low selects it. In this mode the significand is incremented when guard is 1 and at least one of round, sticky or the significand LSB is 1. An exact tie therefore leaves the LSB at 0.
- R2: Mode code 01 rounds toward zero. The significand is truncated, whatever the guard, round and sticky bits are.
- R3: Mode code 10 rounds toward plus infinity. The magnitude is incremented only when the sign is 0 and any of guard, round or sticky is 1.
- R4: Mode code 11 rounds toward minus infinity. The magnitude is incremented only when the sign is 1 and any of guard, round or sticky is 1.
- R5: If rounding carries out of an all-ones significand, the significand becomes 1.0 (stored fraction all zero) and the exponent rises by one.
- R6: Overflow is flagged when the biased exponent after rounding and carry is 255 or more.
- R7: On overflow with the trap disabled and sign 0, the result is +infinity (0x7F800000) in modes 00 and 10. It is +MAX (0x7F7FFFFF) in modes 01 and 11.
- R8: On overflow with the trap disabled and sign 1, the result is -infinity (0xFF800000) in modes 00 and 11. It is -MAX (0xFF7FFFFF) in modes 01 and 10.
- R9: On overflow with the trap enabled, the trap request is 1. The word carries the sign, the rounded fraction and the rounded exponent minus 192. Without overflow the trap request is 0, whatever the enable is.
- R10: The inexact flag is 1 when any of guard, round or sticky is 1, and also on every overflow where the trap is disabled.
- R11: With the output register on, word, flags and output valid appear one clock after an input with valid set. Output valid is 0 one clock after an input with valid clear. Reset clears all outputs to 0.
- R12: A result that does not overflow is packed as sign in bit 31, the low 8 bits of the rounded exponent in bits 30:23, and the rounded fraction in bits 22:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operand is present |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | EXP_W | Biased exponent, signed, widened |
| in_sig | input | FRAC_W+1 | Normalized significand including the leading one |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| rnd_mode | input | 2 | 00 nearest, 01 zero, 10 plus infinity, 11 minus infinity |
| ovf_trap_en | input | 1 | Overflow goes to the trap instead of the default value |
| out_valid | output | 1 | Output word is present |
| out_word | output | 1+EW_OUT+FRAC_W | Packed result |
| out_ovf | output | 1 | Overflow detected |
| out_inexact | output | 1 | Result is not exact |
| out_trap | output | 1 | Trap request |

## Verification
The bench builds the unit with its defaults: a 10-bit signed exponent field, the output register enabled, and an exponent offset of 192. The wide exponent lets inputs far above 254 reach the unit, so both the masked defaults and the rescaled trap values can be tested. The register stage lets every mode, sign and trap combination be checked one cycle after it is applied. Random exponents cluster around the overflow threshold, and random significands often end in all ones, so carries into overflow occur often.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  // Decide whether the magnitude grows by one ULP.
  function automatic logic want_increment(rmode_e mode, logic sgn, logic lsb,
                                          logic g, logic r, logic s);
    logic any_lost;
    any_lost = g | r | s;
    unique case (mode)
      RM_NEAR: want_increment = g & (r | s | lsb);
      RM_ZERO: want_increment = 1'b0;
      RM_POS:  want_increment = ~sgn & any_lost;
      RM_NEG:  want_increment = sgn & any_lost;
      default: want_increment = 1'b0;
    endcase
  endfunction

  // On masked overflow: 1 selects infinity, 0 selects the largest finite value.
  function automatic logic ovf_goes_inf(rmode_e mode, logic sgn);
    unique case (mode)
      RM_NEAR: ovf_goes_inf = 1'b1;
      RM_ZERO: ovf_goes_inf = 1'b0;
      RM_POS:  ovf_goes_inf = ~sgn;
      RM_NEG:  ovf_goes_inf = sgn;
      default: ovf_goes_inf = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
(
  input  logic   sign,
  input  logic   lsb,
  input  logic   guard,
  input  logic   rnd,
  input  logic   sticky,
  input  rmode_e mode,
  output logic   incr,
  output logic   lost
);

  always_comb begin
    incr = want_increment(mode, sign, lsb, guard, rnd, sticky);
    lost = guard | rnd | sticky;
  end

endmodule

// File: rtl/fpr_adjust.sv
module fpr_adjust #(
  parameter int EXP_W = 10,
  parameter int SIG_W = 24
) (
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic        [SIG_W-1:0] sig_in,
  input  logic                    incr,
  output logic        [SIG_W-1:0] sig_out,
  output logic signed [EXP_W:0]   exp_out,
  output logic                    carry
);

  localparam int SUM_W = SIG_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum     = {1'b0, sig_in} + {{SIG_W{1'b0}}, incr};
    carry   = sum[SUM_W-1];
    sig_out = carry ? sum[SUM_W-1:1] : sum[SIG_W-1:0];
    exp_out = {exp_in[EXP_W-1], exp_in} + {{EXP_W{1'b0}}, carry};
  end

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 10,
  parameter int FRAC_W   = 23,
  parameter int EW_OUT   = 8,
  parameter int TRAP_ADJ = 192
) (
  input  logic                      sign,
  input  logic signed [EXP_W:0]     exp_r,
  input  logic        [FRAC_W-1:0]  frac_r,
  input  rmode_e                    mode,
  input  logic                      trap_en,
  input  logic                      lost,
  output logic [EW_OUT+FRAC_W:0]    word,
  output logic                      ovf,
  output logic                      inexact,
  output logic                      trap
);

  localparam int EXP_TOP = (1 << EW_OUT) - 1;
  localparam logic signed [EXP_W:0] TOP_S = (EXP_W+1)'(EXP_TOP);
  localparam logic signed [EXP_W:0] ADJ_S = (EXP_W+1)'(TRAP_ADJ);

  logic signed [EXP_W:0]          trap_exp;
  logic [EW_OUT+FRAC_W:0]         w_inf, w_max, w_norm, w_trap;

  always_comb begin
    ovf      = (exp_r >= TOP_S);
    trap_exp = exp_r - ADJ_S;
    w_inf    = {sign, {EW_OUT{1'b1}}, {FRAC_W{1'b0}}};
    w_max    = {sign, {(EW_OUT-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    w_norm   = {sign, exp_r[EW_OUT-1:0], frac_r};
    w_trap   = {sign, trap_exp[EW_OUT-1:0], frac_r};
    trap     = ovf & trap_en;
    inexact  = lost | (ovf & ~trap_en);
    if (!ovf)         word = w_norm;
    else if (trap_en) word = w_trap;
    else              word = ovf_goes_inf(mode, sign) ? w_inf : w_max;
  end

endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 10,
  parameter int FRAC_W   = 23,
  parameter int EW_OUT   = 8,
  parameter int TRAP_ADJ = 192,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sign,
  input  logic signed [EXP_W-1:0]     in_exp,
  input  logic        [FRAC_W:0]      in_sig,
  input  logic                        in_guard,
  input  logic                        in_round,
  input  logic                        in_sticky,
  input  logic        [1:0]           rnd_mode,
  input  logic                        ovf_trap_en,
  output logic                        out_valid,
  output logic [EW_OUT+FRAC_W:0]      out_word,
  output logic                        out_ovf,
  output logic                        out_inexact,
  output logic                        out_trap
);

  localparam int SIG_W  = FRAC_W + 1;
  localparam int WORD_W = 1 + EW_OUT + FRAC_W;

  rmode_e                 mode;
  logic                   ev_incr;
  logic                   ev_lost;
  logic                   ev_carry;
  logic [SIG_W-1:0]       sig_r;
  logic signed [EXP_W:0]  exp_r;
  logic [WORD_W-1:0]      c_word;
  logic                   c_ovf, c_inexact, c_trap;

  assign mode = rmode_e'(rnd_mode);

  fpr_decide u_decide (
    .sign  (in_sign),
    .lsb   (in_sig[0]),
    .guard (in_guard),
    .rnd   (in_round),
    .sticky(in_sticky),
    .mode  (mode),
    .incr  (ev_incr),
    .lost  (ev_lost)
  );

  fpr_adjust #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_adjust (
    .exp_in (in_exp),
    .sig_in (in_sig),
    .incr   (ev_incr),
    .sig_out(sig_r),
    .exp_out(exp_r),
    .carry  (ev_carry)
  );

  fpr_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EW_OUT(EW_OUT),
             .TRAP_ADJ(TRAP_ADJ)) u_pack (
    .sign   (in_sign),
    .exp_r  (exp_r),
    .frac_r (sig_r[FRAC_W-1:0]),
    .mode   (mode),
    .trap_en(ovf_trap_en),
    .lost   (ev_lost),
    .word   (c_word),
    .ovf    (c_ovf),
    .inexact(c_inexact),
    .trap   (c_trap)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_word    <= '0;
          out_ovf     <= 1'b0;
          out_inexact <= 1'b0;
          out_trap    <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_word    <= c_word;
            out_ovf     <= c_ovf;
            out_inexact <= c_inexact;
            out_trap    <= c_trap;
          end
        end
      end

      // R11: output valid trails input valid by one clock
      a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
      // R9: a registered trap request always comes with a registered overflow
      a_r9_trap_has_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_ovf);
    end else begin : g_comb
      always_comb begin
        out_valid   = in_valid;
        out_word    = c_word;
        out_ovf     = c_ovf;
        out_inexact = c_inexact;
        out_trap    = c_trap;
      end
    end
  endgenerate

  // R2: toward zero never changes significand or exponent
  a_r2_zero_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == RM_ZERO) |-> (!ev_carry && sig_r == in_sig));
  // R5: a carry leaves the fraction all zero
  a_r5_carry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_carry |-> (sig_r[FRAC_W-1:0] == '0 && ev_incr));
  // R9: a trap request needs both overflow and the enable
  a_r9_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    c_trap |-> (c_ovf && ovf_trap_en));
  // R7/R8: a masked overflow yields an exponent field of 254 or 255
  a_r7_masked_range: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ovf && !ovf_trap_en) |-> (c_word[WORD_W-2 -: EW_OUT] >= EW_OUT'((1 << EW_OUT) - 2)));
  // R10: a masked overflow is always inexact
  a_r10_masked_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ovf && !ovf_trap_en) |-> c_inexact);
  // R3/R4: directed modes never grow a magnitude when nothing was lost
  a_r3_no_grow_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_lost) |-> !ev_incr);

endmodule

// File: tb/test_fpr_round_unit.sv
module test_fpr_round_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic signed [9:0] in_exp = '0;
  logic [23:0] in_sig = '0;
  logic        in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        ovf_trap_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_ovf, out_inexact, out_trap;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fpr_round_unit i_fpr_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard),
    .in_round(in_round), .in_sticky(in_sticky), .rnd_mode(rnd_mode),
    .ovf_trap_en(ovf_trap_en), .out_valid(out_valid), .out_word(out_word),
    .out_ovf(out_ovf), .out_inexact(out_inexact), .out_trap(out_trap)
  );

  // Reference: {word, ovf, inexact, trap}
  function automatic logic [34:0] ref_calc(bit sgn, int e, int m, bit g, bit r,
                                           bit s, bit [1:0] md, bit ten);
    bit any, up, big;
    int mm, ee;
    logic [31:0] w;
    any = g | r | s;
    case (md)
      2'd0: up = g && (r || s || (m % 2 == 1));
      2'd1: up = 1'b0;
      2'd2: up = !sgn && any;
      default: up = sgn && any;
    endcase
    mm = m + (up ? 1 : 0);
    ee = e;
    if (mm == 32'h0100_0000) begin mm = 32'h0080_0000; ee = ee + 1; end
    if (ee >= 255) begin
      if (ten) begin
        w = {sgn, 8'(ee - 192), mm[22:0]};
        return {w, 1'b1, any, 1'b1};
      end
      big = (md == 2'd0) || (md == 2'd2 && !sgn) || (md == 2'd3 && sgn);
      w = big ? {sgn, 8'hFF, 23'h0} : {sgn, 8'hFE, 23'h7FFFFF};
      return {w, 1'b1, 1'b1, 1'b0};
    end
    w = {sgn, 8'(ee), mm[22:0]};
    return {w, 1'b0, any, 1'b0};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (one register).
  task automatic run_vec(string tag, bit sgn, int e, int m, bit g, bit r, bit s,
                         bit [1:0] md, bit ten);
    logic [34:0] exp_v, got;
    exp_v = ref_calc(sgn, e, m, g, r, s, md, ten);
    in_valid = 1'b1; in_sign = sgn; in_exp = 10'(e); in_sig = 24'(m);
    in_guard = g; in_round = r; in_sticky = s; rnd_mode = md; ovf_trap_en = ten;
    @(negedge clk);
    got = {out_word, out_ovf, out_inexact, out_trap};
    n_chk++;
    if (!out_valid || got !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got word=%h ovf=%b inx=%b trap=%b vld=%b expected word=%h ovf=%b inx=%b trap=%b vld=1",
               tag, out_word, out_ovf, out_inexact, out_trap, out_valid,
               exp_v[34:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    logic [34:0] pv;
    repeat (3) @(negedge clk);
    // R11: reset state
    n_chk++;
    if (out_valid !== 1'b0 || out_word !== 32'h0 || out_ovf !== 1'b0 ||
        out_inexact !== 1'b0 || out_trap !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got vld=%b word=%h expected vld=0 word=00000000",
               out_valid, out_word);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: ties to even, both parities
    run_vec("R1 tie even stays", 0, 127, 24'h800000, 1, 0, 0, 2'd0, 0);
    run_vec("R1 tie odd rounds", 0, 127, 24'h800001, 1, 0, 0, 2'd0, 0);
    run_vec("R1 above half", 1, 130, 24'h800000, 1, 0, 1, 2'd0, 0);
    // R2: truncation
    run_vec("R2 truncate", 0, 140, 24'hABCDEF, 1, 1, 1, 2'd1, 0);
    // R3 / R4: sign-directed
    run_vec("R3 pos grows", 0, 100, 24'h812345, 0, 0, 1, 2'd2, 0);
    run_vec("R3 neg holds", 1, 100, 24'h812345, 0, 0, 1, 2'd2, 0);
    run_vec("R4 neg grows", 1, 100, 24'h812345, 0, 1, 0, 2'd3, 0);
    run_vec("R4 pos holds", 0, 100, 24'h812345, 0, 1, 0, 2'd3, 0);
    // R5: carry out of all-ones significand
    run_vec("R5 carry", 0, 100, 24'hFFFFFF, 1, 0, 0, 2'd2, 0);
    // R6: carry pushes exponent to 255
    run_vec("R6 carry overflow", 0, 254, 24'hFFFFFF, 1, 1, 0, 2'd0, 0);
    run_vec("R6 no carry at 254", 0, 254, 24'hFFFFFF, 1, 1, 0, 2'd1, 0);
    // R7 / R8: every mode and sign, masked
    for (int md = 0; md < 4; md++) begin
      run_vec("R7 masked positive", 0, 300, 24'h900000, 0, 0, 0, 2'(md), 0);
      run_vec("R8 masked negative", 1, 300, 24'h900000, 0, 0, 0, 2'(md), 0);
    end
    // R9: trap rescaling and trap gated by overflow
    run_vec("R9 trap rescale", 1, 300, 24'hC00001, 1, 0, 0, 2'd0, 1);
    run_vec("R9 trap carry", 0, 254, 24'hFFFFFF, 1, 0, 0, 2'd2, 1);
    run_vec("R9 no ovf no trap", 0, 200, 24'h800000, 0, 0, 0, 2'd0, 1);
    // R10: exact result not inexact; lost bits inexact
    run_vec("R10 exact", 0, 50, 24'hF0F0F0, 0, 0, 0, 2'd3, 0);
    run_vec("R10 sticky only", 1, 50, 24'hF0F0F0, 0, 0, 1, 2'd1, 0);
    // R12: plain packing
    run_vec("R12 packing", 1, 1, 24'hFEDCBA, 0, 0, 0, 2'd0, 0);

    // R11: valid clear propagates, word holds
    pv = {out_word, out_ovf, out_inexact, out_trap};
    in_valid = 1'b0; in_exp = 10'd7;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || {out_word, out_ovf, out_inexact, out_trap} !== pv) begin
      n_bad++;
      $display("FAIL R11 idle: got vld=%b word=%h expected vld=0 word=%h",
               out_valid, out_word, pv[34:3]);
    end

    // Random mix around the overflow edge
    void'($urandom(32'd1357));
    for (int i = 0; i < 600; i++) begin
      bit sg, g, r, s, ten;
      int e, m;
      bit [1:0] md;
      sg  = 1'($urandom);
      md  = 2'($urandom);
      g   = 1'($urandom); r = 1'($urandom); s = 1'($urandom);
      ten = ($urandom % 3) == 0;
      e   = ($urandom % 2 == 0) ? 248 + int'($urandom % 12) : 1 + int'($urandom % 400);
      m   = ($urandom % 4 == 0) ? 32'h00FF_FFFF : int'(32'h0080_0000 | ($urandom & 32'h007F_FFFF));
      pv  = ref_calc(sg, e, m, g, r, s, md, ten);
      if (pv[2])           tag = ten ? "R9 random trap" : (sg ? "R8 random" : "R7 random");
      else if (md == 2'd0) tag = "R1 random";
      else if (md == 2'd1) tag = "R2 random";
      else if (md == 2'd2) tag = "R3 random";
      else                 tag = "R4 random";
      run_vec(tag, sg, e, m, g, r, s, md, ten);
    end

    finish_run();
  end

endmodule